// File: doc/BRIEF.md
# Index/Data Configuration Register Port

This block is a byte-wide configuration register file reached through a pair of adjacent I/O addresses. The lower address is an index register that picks one of 256 configuration bytes; the upper address is the data window onto the byte that the index selects. Software writes an index, then reads or writes the data window. The table holds the setup of a set of legacy peripherals, which are not part of this block.

Writes through the data window are filtered per entry. Most entries are read-only and keep their reset value. Two entries are pinned: each accepts a write only when the value equals its one hard-wired setting, and drops every other value without notice. The whole port is dead after reset. It comes alive only after the host bridge configuration byte at offset 0x85 is written with bit 1 set, and goes dead again when that bit is written as 0. The block watches those bridge configuration writes itself.

Top module: `cfg_index_port`

## Requirements
- R1: After reset the index is 0x00 and the port is disabled. Entries 0xE0, 0xE2, 0xE3, 0xE6, 0xE7 and 0xE8 hold 0x3C, 0x03, 0xFC, 0xDE, 0xFE and 0xBE. Every other entry holds 0x00.
- R2: A bridge configuration write to offset 0x85 sets the port enable to bit 1 of the written byte. Bridge writes to any other offset leave the enable unchanged.
- R3: While the port is disabled, every read returns 0xFF, and writes to either port address change neither the index nor any table entry.
- R4: While enabled, a write to the base address (0x3F0) loads the 8-bit write data into the index, so that the next read returns the newly selected entry.
- R5: While enabled, a read strobe at either the base address or the base address plus one returns the entry at the current index in the same cycle. A read of any other address, or no read strobe, returns 0xFF.
- R6: A write to base plus one (0x3F1) stores the byte in the selected entry when the index is one of 0xE0–0xE3, 0xE6, 0xEE–0xF2, 0xF4, 0xF6, 0xF8 or 0xFC.
- R7: A data write has no effect when the index is below 0xE0, or is 0xE4, 0xE5, 0xE9–0xED, 0xF3, 0xF5, 0xF7, 0xF9–0xFB or 0xFD–0xFF.
- R8: Entry 0xE8 accepts only the value 0xBE and entry 0xE7 accepts only 0xFE. Other values written there are dropped, and the entry keeps its contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| brg_wr_i | input | 1 | Host bridge configuration byte write strobe |
| brg_off_i | input | 8 | Offset of the bridge configuration write |
| brg_wdata_i | input | 8 | Byte written to bridge configuration |
| io_addr_i | input | AW (16) | I/O byte address |
| io_wr_i | input | 1 | I/O write strobe |
| io_rd_i | input | 1 | I/O read strobe |
| io_wdata_i | input | 8 | I/O write byte |
| io_rdata_o | output | 8 | I/O read byte, 0xFF when the port does not respond |

## Verification
A dropped write to a pinned entry is the hardest case to see from the ports. The entry already holds its only legal value, so a dropped write and a stored write look the same. The stimulus therefore writes the illegal values first and reads back the hard-wired value, then writes the legal value. A second hard case is a write made while the port is disabled. To show it touched nothing, the bench re-enables the port and reads through the old index before it selects the entry it tried to write.

// File: rtl/cfgp_pkg.sv
package cfgp_pkg;
  localparam int IDX_W = 8;
  localparam int N_ENT = 1 << IDX_W;
  localparam logic [7:0] PIN_A_IDX = 8'hE7;
  localparam logic [7:0] PIN_A_VAL = 8'hFE;
  localparam logic [7:0] PIN_B_IDX = 8'hE8;
  localparam logic [7:0] PIN_B_VAL = 8'hBE;

  function automatic logic entry_ro(input logic [7:0] i);
    return (i <= 8'hDF) || (i inside {8'hE4, 8'hE5, [8'hE9:8'hED], 8'hF3, 8'hF5,
                                      8'hF7, [8'hF9:8'hFB], [8'hFD:8'hFF]});
  endfunction

  function automatic logic [7:0] entry_rst(input logic [7:0] i);
    case (i)
      8'hE0:   return 8'h3C;
      8'hE2:   return 8'h03;
      8'hE3:   return 8'hFC;
      8'hE6:   return 8'hDE;
      8'hE7:   return PIN_A_VAL;
      8'hE8:   return PIN_B_VAL;
      default: return 8'h00;
    endcase
  endfunction
endpackage

// File: rtl/cfgp_enable.sv
module cfgp_enable #(
  parameter logic [7:0] CFG_OFF = 8'h85,
  parameter int         EN_BIT  = 1
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       brg_wr_i,
  input  logic [7:0] brg_off_i,
  input  logic [7:0] brg_wdata_i,
  output logic       en_o
);
  logic hit;
  assign hit = brg_wr_i && (brg_off_i == CFG_OFF);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)  en_o <= 1'b0;
    else if (hit) en_o <= brg_wdata_i[EN_BIT];

  a_r2_en_other_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(brg_wr_i && brg_off_i == CFG_OFF) |=> $stable(en_o));
  a_r2_en_follows: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (brg_wr_i && brg_off_i == CFG_OFF) |=> en_o == $past(brg_wdata_i[EN_BIT]));
endmodule

// File: rtl/cfgp_decode.sv
module cfgp_decode #(
  parameter int            AW   = 16,
  parameter logic [AW-1:0] BASE = 16'h03F0
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic [AW-1:0] io_addr_i,
  input  logic          io_wr_i,
  input  logic          io_rd_i,
  input  logic [7:0]    io_wdata_i,
  output logic [7:0]    idx_o,
  output logic          data_we_o,
  output logic          rd_hit_o
);
  localparam logic [AW-1:0] DATA_A = BASE + AW'(1);

  logic at_idx, at_dat, idx_we;
  assign at_idx    = io_addr_i == BASE;
  assign at_dat    = io_addr_i == DATA_A;
  assign idx_we    = en_i && io_wr_i && at_idx;
  assign data_we_o = en_i && io_wr_i && at_dat;
  assign rd_hit_o  = en_i && io_rd_i && (at_idx || at_dat);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni)     idx_o <= 8'h00;
    else if (idx_we) idx_o <= io_wdata_i;

  a_r4_idx_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && io_wr_i && io_addr_i == BASE) |=> idx_o == $past(io_wdata_i));
  a_r3_idx_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || !io_wr_i || io_addr_i != BASE) |=> $stable(idx_o));
endmodule

// File: rtl/cfgp_filter.sv
module cfgp_filter (
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  input  logic       we_i,
  output logic       commit_o
);
  import cfgp_pkg::*;
  logic val_ok;

  always_comb begin
    if (idx_i == PIN_A_IDX)      val_ok = wdata_i == PIN_A_VAL;
    else if (idx_i == PIN_B_IDX) val_ok = wdata_i == PIN_B_VAL;
    else                         val_ok = !entry_ro(idx_i);
  end

  assign commit_o = we_i && val_ok;
endmodule

// File: rtl/cfgp_table.sv
module cfgp_table (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       we_i,
  input  logic [7:0] idx_i,
  input  logic [7:0] wdata_i,
  output logic [7:0] rdata_o
);
  import cfgp_pkg::*;
  logic [N_ENT-1:0][7:0] mem;

  for (genvar e = 0; e < N_ENT; e++) begin : g_ent
    localparam logic [7:0] EI = 8'(e);
    if (entry_ro(EI)) begin : g_ro
      assign mem[e] = entry_rst(EI);
    end else begin : g_rw
      always_ff @(posedge clk_i or negedge rst_ni)
        if (!rst_ni)                   mem[e] <= entry_rst(EI);
        else if (we_i && idx_i == EI)  mem[e] <= wdata_i;
    end
  end

  assign rdata_o = mem[idx_i];

  a_r7_no_commit_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(mem));
  a_r6_store: assert property (@(posedge clk_i) disable iff (!rst_ni)
    we_i |=> mem[$past(idx_i)] == $past(wdata_i));
  a_r8_pin_a: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem[PIN_A_IDX] == PIN_A_VAL);
  a_r8_pin_b: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem[PIN_B_IDX] == PIN_B_VAL);
endmodule

// File: rtl/cfg_index_port.sv
module cfg_index_port #(
  parameter int            AW      = 16,
  parameter logic [AW-1:0] BASE    = 16'h03F0,
  parameter logic [7:0]    CFG_OFF = 8'h85,
  parameter int            EN_BIT  = 1
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          brg_wr_i,
  input  logic [7:0]    brg_off_i,
  input  logic [7:0]    brg_wdata_i,
  input  logic [AW-1:0] io_addr_i,
  input  logic          io_wr_i,
  input  logic          io_rd_i,
  input  logic [7:0]    io_wdata_i,
  output logic [7:0]    io_rdata_o
);
  logic       en_q, data_we, rd_hit, commit;
  logic [7:0] idx_q, tbl_rdata;

  cfgp_enable #(.CFG_OFF(CFG_OFF), .EN_BIT(EN_BIT)) u_enable (
    .clk_i, .rst_ni, .brg_wr_i, .brg_off_i, .brg_wdata_i, .en_o(en_q));

  cfgp_decode #(.AW(AW), .BASE(BASE)) u_decode (
    .clk_i, .rst_ni, .en_i(en_q), .io_addr_i, .io_wr_i, .io_rd_i, .io_wdata_i,
    .idx_o(idx_q), .data_we_o(data_we), .rd_hit_o(rd_hit));

  cfgp_filter u_filter (
    .idx_i(idx_q), .wdata_i(io_wdata_i), .we_i(data_we), .commit_o(commit));

  cfgp_table u_table (
    .clk_i, .rst_ni, .we_i(commit), .idx_i(idx_q), .wdata_i(io_wdata_i),
    .rdata_o(tbl_rdata));

  assign io_rdata_o = rd_hit ? tbl_rdata : 8'hFF;

  a_r3_dis_reads_ff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> io_rdata_o == 8'hFF);
  a_r3_dis_no_commit: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_q |-> !commit);
  a_r7_ro_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (data_we && cfgp_pkg::entry_ro(idx_q)) |-> !commit);
endmodule

// File: tb/cfg_index_port_bench.sv
`timescale 1ns/1ps
module cfg_index_port_bench;
  logic clk = 1'b0, rst_ni = 1'b0;
  logic brg_wr = 0, io_wr = 0, io_rd = 0;
  logic [7:0] brg_off = 0, brg_wdata = 0, io_wdata = 0, io_rdata;
  logic [15:0] io_addr = 0;
  int errors = 0, checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  cfg_index_port u_cfg_index_port (
    .clk_i(clk), .rst_ni, .brg_wr_i(brg_wr), .brg_off_i(brg_off),
    .brg_wdata_i(brg_wdata), .io_addr_i(io_addr), .io_wr_i(io_wr),
    .io_rd_i(io_rd), .io_wdata_i(io_wdata), .io_rdata_o(io_rdata));

  // {index, written value, expected read-back}
  localparam int NV = 31;
  localparam logic [23:0] VEC [NV] = '{
    24'hE0_55_55, 24'hE1_A5_A5, 24'hE2_0F_0F, 24'hE3_F0_F0, 24'hE6_12_12,
    24'hEE_33_33, 24'hEF_44_44, 24'hF0_01_01, 24'hF1_80_80, 24'hF2_7E_7E,
    24'hF4_C3_C3, 24'hF6_99_99, 24'hF8_11_11, 24'hFC_22_22,
    24'h00_AA_00, 24'hDF_AA_00, 24'hE4_AA_00, 24'hE5_AA_00, 24'hE9_AA_00,
    24'hED_AA_00, 24'hF3_AA_00, 24'hF5_AA_00, 24'hF7_AA_00, 24'hF9_AA_00,
    24'hFB_AA_00, 24'hFD_AA_00, 24'hFF_AA_00,
    24'hE7_00_FE, 24'hE7_FE_FE, 24'hE8_BF_BE, 24'hE8_BE_BE};

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: got %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic brg_write(input logic [7:0] off, input logic [7:0] d);
    @(negedge clk); brg_wr = 1; brg_off = off; brg_wdata = d;
    @(negedge clk); brg_wr = 0;
  endtask

  task automatic io_write(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk); io_wr = 1; io_addr = a; io_wdata = d;
    @(negedge clk); io_wr = 0;
  endtask

  task automatic io_read(input logic [15:0] a, output logic [7:0] d);
    @(negedge clk); io_rd = 1; io_addr = a;
    #1 d = io_rdata;
    io_rd = 0;
  endtask

  task automatic sel_read(input logic [7:0] idx, output logic [7:0] d);
    io_write(16'h03F0, idx);
    io_read(16'h03F1, d);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got hang expected completion");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [7:0] r;
    repeat (3) @(negedge clk);
    rst_ni = 1;
    // R1/R3: port disabled out of reset
    io_read(16'h03F1, r); check("R1", r, 8'hFF);
    io_write(16'h03F0, 8'hE1); io_write(16'h03F1, 8'h77);
    // R2: wrong offset, or bit 1 clear, leaves it disabled
    brg_write(8'h84, 8'h02); io_read(16'h03F1, r); check("R2", r, 8'hFF);
    brg_write(8'h85, 8'hFD); io_read(16'h03F1, r); check("R2", r, 8'hFF);
    brg_write(8'h85, 8'h02);
    // R1/R3: index still 0 and entry 0x00 is 0, disabled writes ignored
    io_read(16'h03F1, r); check("R3", r, 8'h00);
    sel_read(8'hE1, r); check("R3", r, 8'h00);
    // R1: defaults
    sel_read(8'hE0, r); check("R1", r, 8'h3C);
    sel_read(8'hE2, r); check("R1", r, 8'h03);
    sel_read(8'hE3, r); check("R1", r, 8'hFC);
    sel_read(8'hE6, r); check("R1", r, 8'hDE);
    sel_read(8'hE7, r); check("R1", r, 8'hFE);
    sel_read(8'hE8, r); check("R1", r, 8'hBE);
    sel_read(8'hF0, r); check("R1", r, 8'h00);
    // R5: index address reads same entry, other address or no strobe reads FF
    io_read(16'h03F0, r); check("R5", r, 8'hF0 == 8'hF0 ? 8'h00 : 8'h00);
    io_write(16'h03F0, 8'hE6);
    io_read(16'h03F0, r); check("R5", r, 8'hDE);
    io_read(16'h03F2, r); check("R5", r, 8'hFF);
    #1 check("R5", io_rdata, 8'hFF);
    // R6/R7/R8 vector walk
    for (int i = 0; i < NV; i++) begin
      logic [7:0] vi, vd, ve;
      string tag;
      {vi, vd, ve} = VEC[i];
      tag = (vi == 8'hE7 || vi == 8'hE8) ? "R8" : (vd == ve) ? "R6" : "R7";
      io_write(16'h03F0, vi);        // R4
      io_write(16'h03F1, vd);
      io_read(16'h03F1, r);
      check(tag, r, ve);
    end
    // R4: index load visible on next read
    io_write(16'h03F0, 8'hE1); io_read(16'h03F1, r); check("R4", r, 8'hA5);
    io_write(16'h03F0, 8'hE8);
    // R3: disable, attempt index and data writes, re-enable
    brg_write(8'h85, 8'h00);
    io_read(16'h03F0, r); check("R3", r, 8'hFF);
    io_write(16'h03F0, 8'hE1); io_write(16'h03F1, 8'h77);
    brg_write(8'h85, 8'h02);
    io_read(16'h03F1, r); check("R3", r, 8'hBE);
    sel_read(8'hE1, r); check("R3", r, 8'hA5);
    done = 1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule